// File: doc/BRIEF.md
# SAR ADC Conversion Controller

This block holds the digital side of a four-input, 8-bit successive-approximation converter. Software talks to it through one 8-bit control register and one result register. The block drives the analog input selector and the 8-bit trial code. It reads back a single comparator bit that tells whether the selected input is at or above the trial code. The multiplexer, trial DAC and comparator sit outside the block.

A conversion runs for a fixed number of ticks of the chosen conversion clock. That clock is either the machine-cycle tick or a free-running auxiliary tick. The first ticks of a conversion go to sampling and settling. Each of the remaining eight ticks then decides one result bit, starting at the MSB.

The start bit and the done flag together form an interlock. While either one is set:
- further starts are refused;
- the channel and clock source stay frozen;
- the enable bit cannot be cleared.

The done flag can raise an interrupt. A power-down request cancels a conversion that runs on the machine-cycle tick. A conversion that runs on the auxiliary tick keeps going through power-down.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, the following all read 0: the control register, the result, the trial code and the interrupt output.
- R2: Control register layout:
  - bit 7 is enable;
  - bit 4 is done;
  - bit 3 is start/busy;
  - bit 2 is clock select (0 = machine tick, 1 = auxiliary tick);
  - bits 1:0 are the channel.

  A write with bit 3 set starts a conversion only when bit 7 of the same write is 1 and both start and done currently read 0. Start then reads 1 for the whole conversion.
- R3: While start or done reads 1, a write that sets bit 3 is ignored. A write of 0 to bit 3 never stops a running conversion.
- R4: The channel and clock-select fields change only on a write made while start and done both read 0. The write that starts a conversion may also change the channel.
- R5: A write with bit 7 clear disables the block only while start and done both read 0. Otherwise enable stays 1.
- R6: A conversion lasts 31 ticks of the selected clock, and done sets after the 31st. Start stays 1 together with done for exactly one further machine tick and then clears.
- R7: The result is found by binary search from the MSB down. A trial bit is kept when the comparator reads 1, so for any input level the result equals that level (0x00 and 0xFF included).
- R8: The result register changes only when a conversion completes. It holds its value through later ignored writes, through aborts and through input changes.
- R9: The interrupt output is 1 one clock after done and the interrupt enable are both 1. It is 0 one clock after either of them is 0.
- R10: If power-down is 1 while a conversion on the machine tick runs, that conversion stops. Start clears, done stays 0 and the result is not updated. A conversion on the auxiliary tick ignores power-down.
- R11: Writing 0 to bit 4 clears done. Writing 1 to bit 4 has no effect. Only a completed conversion sets done.
- R12: The channel-select output always equals the channel field of the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock pulse per machine cycle |
| rc_tick | input | 1 | One-clock pulse of the auxiliary conversion clock |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| ctrl_rd | output | 8 | Control register read value |
| result | output | 8 | Last completed conversion result |
| irq_en | input | 1 | Interrupt enable for the done flag |
| irq | output | 1 | Interrupt request |
| pwr_down | input | 1 | Power-down request |
| cmp_in | input | 1 | Comparator: 1 when input is at or above the trial code |
| chan_sel | output | 2 | Analog channel select |
| dac_code | output | 8 | Trial code for the DAC |

## Verification
The hardest state to reach is the one-machine-cycle overlap in which start and done both read 1. It is followed by a window in which done alone locks the register. The bench runs a full conversion on a slow machine tick and catches the first clock in which done appears. It then counts clocks until start drops. While done is still set, it tries a restart, a channel change, a clock change and a disable. The abort case is reached by raising power-down partway through a machine-tick conversion. The same stimulus is then repeated with the auxiliary clock selected, to show that the conversion survives.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  localparam int CTRL_W  = 8;
  localparam int EN_B    = 7;
  localparam int DONE_B  = 4;
  localparam int START_B = 3;
  localparam int CLK_B   = 2;
endpackage

// File: rtl/sar_adc_regs.sv
module sar_adc_regs
  import sar_adc_pkg::*;
#(
  parameter int CH_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              finish,
  input  logic              abort,
  output logic              start_pulse,
  output logic              clk_sel,
  output logic              done,
  output logic [CH_W-1:0]   chan,
  output logic [CTRL_W-1:0] ctrl_rd
);
  logic en_q, start_q, done_q, clk_q, closing_q;
  logic [CH_W-1:0] chan_q;
  logic idle;
  logic [1:0] unused_rsv;

  assign unused_rsv  = wr_data[6:5];
  assign idle        = !start_q && !done_q;
  assign start_pulse = wr_en && wr_data[START_B] && wr_data[EN_B] && idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      start_q   <= 1'b0;
      done_q    <= 1'b0;
      clk_q     <= 1'b0;
      closing_q <= 1'b0;
      chan_q    <= '0;
    end else begin
      if (wr_en) begin
        if (wr_data[EN_B]) en_q <= 1'b1;
        else if (idle)     en_q <= 1'b0;
        if (!wr_data[DONE_B]) done_q <= 1'b0;
        if (idle) begin
          chan_q <= wr_data[CH_W-1:0];
          clk_q  <= wr_data[CLK_B];
        end
      end
      if (start_pulse) start_q <= 1'b1;
      if (finish) begin
        done_q    <= 1'b1;
        closing_q <= 1'b1;
      end else if (closing_q && tick) begin
        start_q   <= 1'b0;
        closing_q <= 1'b0;
      end
      if (abort) start_q <= 1'b0;
    end
  end

  assign clk_sel = clk_q;
  assign done    = done_q;
  assign chan    = chan_q;

  always_comb begin
    ctrl_rd            = '0;
    ctrl_rd[EN_B]      = en_q;
    ctrl_rd[DONE_B]    = done_q;
    ctrl_rd[START_B]   = start_q;
    ctrl_rd[CLK_B]     = clk_q;
    ctrl_rd[CH_W-1:0]  = chan_q;
  end

  // R5: enable survives while the interlock is set
  a_r5_enable_held: assert property (@(posedge clk) disable iff (rst)
    (en_q && (start_q || done_q)) |=> en_q);
  // R3: no restart out of a pending done
  a_r3_no_restart: assert property (@(posedge clk) disable iff (rst)
    (done_q && !start_q) |=> !start_q);
  // R4: channel and clock frozen while locked
  a_r4_chan_locked: assert property (@(posedge clk) disable iff (rst)
    (start_q || done_q) |=> ($stable(chan_q) && $stable(clk_q)));
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq #(
  parameter int DATA_W     = 8,
  parameter int CONV_TICKS = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rc_tick,
  input  logic              clk_sel,
  input  logic              pwr_down,
  input  logic              start_pulse,
  input  logic              cmp_in,
  output logic              finish,
  output logic              abort,
  output logic [DATA_W-1:0] dac_code,
  output logic [DATA_W-1:0] result
);
  localparam int CNT_W = $clog2(CONV_TICKS);
  localparam logic [CNT_W-1:0] LAST_C   = CNT_W'(CONV_TICKS - 1);
  localparam logic [CNT_W-1:0] SAMPLE_C = CNT_W'(CONV_TICKS - DATA_W);
  localparam logic [DATA_W-1:0] TOP_BIT = {1'b1, {(DATA_W-1){1'b0}}};

  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] acc_q, mask_q, dac_q, res_q, acc_n;
  logic              step, in_sar;

  assign step   = clk_sel ? rc_tick : tick;
  assign abort  = busy_q && pwr_down && !clk_sel;
  assign in_sar = cnt_q >= SAMPLE_C;
  assign acc_n  = cmp_in ? (acc_q | mask_q) : acc_q;
  assign finish = busy_q && !abort && step && (cnt_q == LAST_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= '0;
      mask_q <= '0;
      dac_q  <= '0;
      res_q  <= '0;
    end else if (start_pulse) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      acc_q  <= '0;
      mask_q <= TOP_BIT;
      dac_q  <= TOP_BIT;
    end else if (abort) begin
      busy_q <= 1'b0;
    end else if (busy_q && step) begin
      cnt_q <= cnt_q + 1'b1;
      if (in_sar) begin
        acc_q  <= acc_n;
        mask_q <= mask_q >> 1;
        dac_q  <= acc_n | (mask_q >> 1);
      end
      if (finish) begin
        busy_q <= 1'b0;
        res_q  <= acc_n;
      end
    end
  end

  assign dac_code = dac_q;
  assign result   = res_q;

  // R6: step counter never passes the last conversion tick
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q <= LAST_C));
  // R10: an abort leaves the sequencer idle and the result untouched
  a_r10_abort_idle: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!busy_q && $stable(res_q)));
  // R8: result moves only on completion
  a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
    !finish |=> $stable(res_q));
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CH_W       = 2,
  parameter int CONV_TICKS = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rc_tick,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_rd,
  output logic [DATA_W-1:0] result,
  input  logic              irq_en,
  output logic              irq,
  input  logic              pwr_down,
  input  logic              cmp_in,
  output logic [CH_W-1:0]   chan_sel,
  output logic [DATA_W-1:0] dac_code
);
  logic start_pulse, clk_sel, done, finish, abort, irq_q;

  sar_adc_regs #(.CH_W(CH_W)) u_regs (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .finish(finish), .abort(abort), .start_pulse(start_pulse),
    .clk_sel(clk_sel), .done(done), .chan(chan_sel), .ctrl_rd(ctrl_rd)
  );

  sar_adc_seq #(.DATA_W(DATA_W), .CONV_TICKS(CONV_TICKS)) u_seq (
    .clk(clk), .rst(rst), .tick(tick), .rc_tick(rc_tick), .clk_sel(clk_sel),
    .pwr_down(pwr_down), .start_pulse(start_pulse), .cmp_in(cmp_in),
    .finish(finish), .abort(abort), .dac_code(dac_code), .result(result)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= done && irq_en;
  end
  assign irq = irq_q;

  // R9: request follows flag and enable by one clock
  a_r9_irq_raise: assert property (@(posedge clk) disable iff (rst)
    (done && irq_en) |=> irq);
  a_r9_irq_drop: assert property (@(posedge clk) disable iff (rst)
    !(done && irq_en) |=> !irq);
endmodule

// File: tb/sim_sar_adc_ctrl.sv
module sim_sar_adc_ctrl;
  localparam int DIV = 4;
  localparam int RDIV = 3;
  localparam logic [7:0] EN = 8'h80, DN = 8'h10, ST = 8'h08, CK = 8'h04;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, irq_en = 1'b0, pwr_down = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] ctrl_rd, result, dac_code;
  logic irq, cmp_in;
  logic [1:0] chan_sel;
  logic [7:0] ain [4];
  int div_c = 0, rdiv_c = 0;
  logic tick, rc_tick;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;
  always @(posedge clk) begin
    div_c  <= (div_c == DIV - 1) ? 0 : div_c + 1;
    rdiv_c <= (rdiv_c == RDIV - 1) ? 0 : rdiv_c + 1;
  end
  assign tick    = (div_c == DIV - 1);
  assign rc_tick = (rdiv_c == RDIV - 1);
  assign cmp_in  = (ain[chan_sel] >= dac_code);

  sar_adc_ctrl u0 (
    .clk(clk), .rst(rst), .tick(tick), .rc_tick(rc_tick), .wr_en(wr_en),
    .wr_data(wr_data), .ctrl_rd(ctrl_rd), .result(result), .irq_en(irq_en),
    .irq(irq), .pwr_down(pwr_down), .cmp_in(cmp_in), .chan_sel(chan_sel),
    .dac_code(dac_code)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_ticks(input int n, input bit use_rc);
    int k = 0;
    while (k < n) begin
      if (use_rc ? rc_tick : tick) k++;
      @(negedge clk);
    end
  endtask

  task automatic run_count(input bit use_rc, output int n);
    n = 0;
    while (!ctrl_rd[4] && n < 100) begin
      if (use_rc ? rc_tick : tick) n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R1 ctrl", ctrl_rd, 0);
    check("R1 result", result, 0);
    check("R1 dac", dac_code, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_basic();
    int n, c;
    irq_en = 1'b1; ain[1] = 8'hA5;
    wr(EN | ST | 8'd1);
    check("R2 start reads 1", ctrl_rd[3], 1);
    check("R4 channel set with start", chan_sel, 1);
    check("R12 chan output", chan_sel, ctrl_rd[1:0]);
    run_count(1'b0, n);
    check("R6 tick count", n, 31);
    check("R6 start with done", ctrl_rd[3], 1);
    c = 0;
    while (ctrl_rd[3] && c < 50) begin @(negedge clk); c++; end
    check("R6 overlap clocks", c, DIV);
    check("R7 result A5", result, 8'hA5);
    check("R9 irq raised", irq, 1);
  endtask

  task automatic t_locked();
    wr(EN | DN | ST | CK | 8'd2);
    check("R3 start refused", ctrl_rd[3], 0);
    check("R4 chan frozen", chan_sel, 1);
    check("R4 clk frozen", ctrl_rd[2], 0);
    wait_ticks(40, 1'b0);
    check("R8 result held", result, 8'hA5);
    wr(DN | 8'd1);
    check("R5 enable held", ctrl_rd[7], 1);
    wr(EN | 8'd1);
    check("R11 done cleared", ctrl_rd[4], 0);
    @(negedge clk);
    check("R9 irq dropped", irq, 0);
    wr(EN | DN | 8'd1);
    check("R11 write 1 no effect", ctrl_rd[4], 0);
  endtask

  task automatic t_busy();
    int n;
    ain[0] = 8'h00;
    wr(EN | ST | 8'd0);
    wait_ticks(5, 1'b0);
    wr(EN | ST | CK | 8'd3);
    check("R4 chan busy", chan_sel, 0);
    check("R4 clk busy", ctrl_rd[2], 0);
    wr(8'h00);
    check("R3 start not stopped", ctrl_rd[3], 1);
    check("R5 enable busy", ctrl_rd[7], 1);
    run_count(1'b0, n);
    check("R7 result 00", result, 8'h00);
    ain[0] = 8'h55;
    wait_ticks(3, 1'b0);
    check("R8 result after input change", result, 8'h00);
    wr(EN | 8'd0);
  endtask

  task automatic t_pd();
    ain[3] = 8'hFF;
    wr(EN | ST | 8'd3);
    wait_ticks(10, 1'b0);
    @(negedge clk); pwr_down = 1'b1;
    @(negedge clk); @(negedge clk); pwr_down = 1'b0;
    check("R10 start cleared", ctrl_rd[3], 0);
    wait_ticks(40, 1'b0);
    check("R10 no done", ctrl_rd[4], 0);
    check("R10 result kept", result, 8'h00);
    check("R10 no irq", irq, 0);
  endtask

  task automatic t_rc();
    int n;
    wr(EN | CK | 8'd2);
    check("R4 clk select idle", ctrl_rd[2], 1);
    ain[2] = 8'h3C;
    pwr_down = 1'b1;
    wr(EN | CK | ST | 8'd2);
    run_count(1'b1, n);
    check("R6 rc tick count", n, 31);
    check("R10 rc survives", result, 8'h3C);
    pwr_down = 1'b0;
    wr(EN | CK | 8'd2);
    wr(EN | 8'd3);
  endtask

  task automatic t_ff();
    int n;
    wr(EN | ST | 8'd3);
    run_count(1'b0, n);
    check("R7 result FF", result, 8'hFF);
    wait_ticks(2, 1'b0);
    wr(EN | 8'd3);
  endtask

  task automatic t_noen();
    wr(8'h00);
    check("R5 disable idle", ctrl_rd[7], 0);
    wr(ST | 8'd1);
    check("R2 start needs enable", ctrl_rd[3], 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) ain[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_locked();
    t_busy();
    t_pd();
    t_rc();
    t_ff();
    t_noen();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule